// File: doc/BRIEF.md
# Double-Buffered Frame Address Generator

This block turns a serviced time-slot (a mode, a channel number and a stream number) into a 13-bit address for an external dual-port memory. Each request has a direction. A write stores a received channel byte into the receive region. A read fetches a transmit channel byte from the transmit region. The memory is split into two blocks. The block runs on one while a host processes the other, and the two swap at every frame.

Reads and writes each keep their own block flag. Near a frame edge the scheduler can therefore still be writing late channels of frame n while it is already reading the early channels of frame n+1 from the other block. Each flag flips once per frame, on the access to that direction's final slot. The host uses the flag edges as block-complete notifications.

The address for an accepted request is registered, so it appears one clock after the request. It is meant to sit on the memory bus one cycle ahead of the access strobe that a neighbouring block drives.

Top module: `dbuf_addr_gen`

## Requirements
- R1: While reset is low and after it is released, `addr_valid_o`, `rd_blk_o` and `wr_blk_o` are 0. The latched mode is 24 streams at the slow rate (code 2'b00).
- R2: Mode 2'b00 (24 streams, 32 channels). The address is 24·C+S. A write adds 0x400. Block 1 adds 0x800. Address bit 12 is always 0.
- R3: Mode 2'b01 (24 streams, 64 channels). The address is 24·C+S. A write adds 0x800. Block 1 adds 0x1000.
- R4: Mode 2'b10 (12 in / 12 out, 128 channels). Writes take streams 0..11 at 12·C+S+0x800. Reads take streams 12..23 at 12·C+(S−12). Block 1 adds 0x1000.
- R5: Mode 2'b11, slow streams 0..15 (32 channels). The address is 16·C+S. A write adds 0x800. Block 1 adds 0x1000.
- R6: Mode 2'b11, fast streams 16..23 (128 channels). A read is at 8·C+(S−16)+0x400. A write is at 8·C+(S−16)+0xC00. Block 1 adds 0x1000.
- R7: An accepted request appears on `addr_o`, `addr_valid_o` and `addr_we_o` one clock after it is presented. `addr_valid_o` is low in every other cycle.
- R8: `rd_blk_o` flips on the same edge that presents the address of the frame's final read. The final read is (C31,S23) in mode 00, (C63,S23) in mode 01, (C127,S23) in mode 10. In mode 11 it is the later of (C127,S23) and (C31,S15) once both have been read. That final address still uses the old block.
- R9: `wr_blk_o` follows the same rule for writes. The final write in mode 10 is (C127,S11).
- R10: Reads use the block given by `rd_blk_o` and writes use the block given by `wr_blk_o`, independently of each other.
- R11: A request whose channel or stream is outside the latched mode's range is ignored. It produces no address and leaves both flags unchanged.
- R12: `mode_i` is latched only in a cycle with `frame_start_i` high. It applies to requests from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Rate/layout mode, latched at frame start |
| frame_start_i | input | 1 | Frame-start event |
| req_valid_i | input | 1 | Slot request present |
| req_we_i | input | 1 | 1 = store received byte, 0 = fetch transmit byte |
| req_chan_i | input | 7 | Channel number |
| req_strm_i | input | 5 | Stream number |
| addr_o | output | 13 | Registered memory address |
| addr_valid_o | output | 1 | Address valid |
| addr_we_o | output | 1 | Direction of the presented address |
| rd_blk_o | output | 1 | Read block flag / read-complete toggle |
| wr_blk_o | output | 1 | Write block flag / write-complete toggle |

## Verification
Two things can fall on the same clock edge. One is the final-slot access that flips a block flag. The other is the next request, which must already use the flipped block even though the final address itself still carries the old one. The bench provokes this by issuing requests back to back across each direction's final slot, in every mode, and in both arrival orders of the two final slots in mixed mode. A scoreboard compares every presented address against a model that applies the old block to the final access and the new block to the access that follows, and it checks the flags directly after each final slot.

// File: rtl/dbuf_ag_pkg.sv
package dbuf_ag_pkg;
  typedef enum logic [1:0] {
    MODE_S2     = 2'b00,
    MODE_S4     = 2'b01,
    MODE_SPLIT8 = 2'b10,
    MODE_MIXED  = 2'b11
  } mode_e;
endpackage

// File: rtl/dbuf_ag_slot_dec.sv
module dbuf_ag_slot_dec
  import dbuf_ag_pkg::*;
#(
  parameter int N_STRM  = 24,
  parameter int CH_BASE = 32,
  parameter int CHAN_W  = 7,
  parameter int STRM_W  = 5
) (
  input  mode_e              mode_i,
  input  logic               we_i,
  input  logic [CHAN_W-1:0]  chan_i,
  input  logic [STRM_W-1:0]  strm_i,
  output logic               ok_o,
  output logic               fast_o,
  output logic [STRM_W-1:0]  idx_o,
  output logic               fin_a_o,
  output logic               fin_b_o
);
  localparam int SLOW_N = N_STRM * 2 / 3;
  localparam logic [CHAN_W-1:0] C1L = CHAN_W'(CH_BASE - 1);
  localparam logic [CHAN_W-1:0] C2L = CHAN_W'(2 * CH_BASE - 1);
  localparam logic [CHAN_W-1:0] C4L = CHAN_W'(4 * CH_BASE - 1);
  localparam logic [STRM_W-1:0] S_LAST  = STRM_W'(N_STRM - 1);
  localparam logic [STRM_W-1:0] S_HALF  = STRM_W'(N_STRM / 2);
  localparam logic [STRM_W-1:0] S_HLAST = STRM_W'(N_STRM / 2 - 1);
  localparam logic [STRM_W-1:0] S_SLOW  = STRM_W'(SLOW_N);
  localparam logic [STRM_W-1:0] S_SLAST = STRM_W'(SLOW_N - 1);

  always_comb begin
    ok_o    = 1'b0;
    fast_o  = 1'b0;
    idx_o   = strm_i;
    fin_a_o = 1'b0;
    fin_b_o = 1'b0;
    unique case (mode_i)
      MODE_S2: begin
        ok_o    = (chan_i <= C1L) && (strm_i <= S_LAST);
        fin_a_o = (chan_i == C1L) && (strm_i == S_LAST);
      end
      MODE_S4: begin
        ok_o    = (chan_i <= C2L) && (strm_i <= S_LAST);
        fin_a_o = (chan_i == C2L) && (strm_i == S_LAST);
      end
      MODE_SPLIT8: begin
        if (we_i) begin
          ok_o    = (strm_i < S_HALF);
          fin_a_o = (chan_i == C4L) && (strm_i == S_HLAST);
        end else begin
          ok_o    = (strm_i >= S_HALF) && (strm_i <= S_LAST);
          idx_o   = strm_i - S_HALF;
          fin_a_o = (chan_i == C4L) && (strm_i == S_LAST);
        end
      end
      MODE_MIXED: begin
        if (strm_i < S_SLOW) begin
          ok_o    = (chan_i <= C1L);
          fin_b_o = (chan_i == C1L) && (strm_i == S_SLAST);
        end else begin
          ok_o    = (strm_i <= S_LAST);
          fast_o  = 1'b1;
          idx_o   = strm_i - S_SLOW;
          fin_a_o = (chan_i == C4L) && (strm_i == S_LAST);
        end
      end
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dbuf_ag_addr_calc.sv
module dbuf_ag_addr_calc
  import dbuf_ag_pkg::*;
#(
  parameter int N_STRM = 24,
  parameter int ADDR_W = 13,
  parameter int CHAN_W = 7,
  parameter int STRM_W = 5
) (
  input  mode_e              mode_i,
  input  logic               we_i,
  input  logic               fast_i,
  input  logic               blk_i,
  input  logic [CHAN_W-1:0]  chan_i,
  input  logic [STRM_W-1:0]  idx_i,
  output logic [ADDR_W-1:0]  addr_o
);
  localparam int SLOW_N = N_STRM * 2 / 3;
  localparam int FAST_N = N_STRM - SLOW_N;
  localparam logic [ADDR_W-1:0] M_FULL = ADDR_W'(N_STRM);
  localparam logic [ADDR_W-1:0] M_HALF = ADDR_W'(N_STRM / 2);
  localparam logic [ADDR_W-1:0] M_SLOW = ADDR_W'(SLOW_N);
  localparam logic [ADDR_W-1:0] M_FAST = ADDR_W'(FAST_N);
  localparam logic [ADDR_W-1:0] R_Q = ADDR_W'(1) << (ADDR_W - 3);
  localparam logic [ADDR_W-1:0] R_H = ADDR_W'(1) << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] R_F = ADDR_W'(1) << (ADDR_W - 1);

  logic [ADDR_W-1:0] cx, ix, mult, reg_off, blk_off;

  always_comb begin
    cx = ADDR_W'(chan_i);
    ix = ADDR_W'(idx_i);
    unique case (mode_i)
      MODE_S2: begin
        mult    = M_FULL;
        reg_off = we_i ? R_Q : '0;
        blk_off = R_H;
      end
      MODE_S4: begin
        mult    = M_FULL;
        reg_off = we_i ? R_H : '0;
        blk_off = R_F;
      end
      MODE_SPLIT8: begin
        mult    = M_HALF;
        reg_off = we_i ? R_H : '0;
        blk_off = R_F;
      end
      default: begin
        mult    = fast_i ? M_FAST : M_SLOW;
        if (fast_i) reg_off = we_i ? (R_H | R_Q) : R_Q;
        else        reg_off = we_i ? R_H : '0;
        blk_off = R_F;
      end
    endcase
    addr_o = cx * mult + ix + reg_off + (blk_i ? blk_off : '0);
  end
endmodule

// File: rtl/dbuf_ag_blk_track.sv
module dbuf_ag_blk_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic mixed_i,
  input  logic fin_a_i,
  input  logic fin_b_i,
  output logic blk_o
);
  logic pend_a_q, pend_b_q, done;

  // mixed mode: frame ends when both final slots were seen, either order
  assign done = hit_i && (mixed_i ? ((fin_a_i && pend_b_q) || (fin_b_i && pend_a_q))
                                  : fin_a_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_o    <= 1'b0;
      pend_a_q <= 1'b0;
      pend_b_q <= 1'b0;
    end else begin
      if (done) blk_o <= ~blk_o;
      if (!mixed_i || done) begin
        pend_a_q <= 1'b0;
        pend_b_q <= 1'b0;
      end else if (hit_i) begin
        if (fin_a_i) pend_a_q <= 1'b1;
        if (fin_b_i) pend_b_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbuf_addr_gen.sv
module dbuf_addr_gen
  import dbuf_ag_pkg::*;
#(
  parameter int N_STRM  = 24,
  parameter int CH_BASE = 32,
  parameter int ADDR_W  = 13,
  localparam int CHAN_W = $clog2(CH_BASE * 4),
  localparam int STRM_W = $clog2(N_STRM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              frame_start_i,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [CHAN_W-1:0] req_chan_i,
  input  logic [STRM_W-1:0] req_strm_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_valid_o,
  output logic              addr_we_o,
  output logic              rd_blk_o,
  output logic              wr_blk_o
);
  mode_e              mode_q;
  logic               ok, fast, fin_a, fin_b, acc, cur_blk;
  logic [STRM_W-1:0]  idx;
  logic [ADDR_W-1:0]  addr_d;
  logic [1:0]         hit, blk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            mode_q <= MODE_S2;
    else if (frame_start_i) mode_q <= mode_e'(mode_i);
  end

  dbuf_ag_slot_dec #(
    .N_STRM(N_STRM), .CH_BASE(CH_BASE), .CHAN_W(CHAN_W), .STRM_W(STRM_W)
  ) u_dec (
    .mode_i(mode_q), .we_i(req_we_i), .chan_i(req_chan_i), .strm_i(req_strm_i),
    .ok_o(ok), .fast_o(fast), .idx_o(idx), .fin_a_o(fin_a), .fin_b_o(fin_b)
  );

  assign acc     = req_valid_i && ok;
  assign cur_blk = req_we_i ? blk[1] : blk[0];

  for (genvar d = 0; d < 2; d++) begin : g_dir
    assign hit[d] = acc && ((d == 1) ? req_we_i : !req_we_i);
    dbuf_ag_blk_track u_trk (
      .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit[d]),
      .mixed_i(mode_q == MODE_MIXED), .fin_a_i(fin_a), .fin_b_i(fin_b),
      .blk_o(blk[d])
    );
  end

  dbuf_ag_addr_calc #(
    .N_STRM(N_STRM), .ADDR_W(ADDR_W), .CHAN_W(CHAN_W), .STRM_W(STRM_W)
  ) u_calc (
    .mode_i(mode_q), .we_i(req_we_i), .fast_i(fast), .blk_i(cur_blk),
    .chan_i(req_chan_i), .idx_i(idx), .addr_o(addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o       <= '0;
      addr_valid_o <= 1'b0;
      addr_we_o    <= 1'b0;
    end else begin
      addr_valid_o <= acc;
      if (acc) begin
        addr_o    <= addr_d;
        addr_we_o <= req_we_i;
      end
    end
  end

  assign rd_blk_o = blk[0];
  assign wr_blk_o = blk[1];
endmodule

// File: rtl/dbuf_addr_gen_chk.sv
module dbuf_addr_gen_chk
  import dbuf_ag_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_we_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              addr_valid_o,
  input logic              addr_we_o,
  input logic              rd_blk_o,
  input logic              wr_blk_o,
  input mode_e             mode_q
);
  a_r7_valid_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> $past(req_valid_i));

  a_r7_dir_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> (addr_we_o == $past(req_we_i)));

  a_r8_rd_flip_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rd_blk_o) |-> (addr_valid_o && !addr_we_o));

  a_r9_wr_flip_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wr_blk_o) |-> (addr_valid_o && addr_we_o));

  a_r2_top_bit_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o && $past(mode_q) == MODE_S2) |-> !addr_o[ADDR_W-1]);

  a_r10_rd_block_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o && !addr_we_o && $past(mode_q) != MODE_S2)
      |-> (addr_o[ADDR_W-1] == $past(rd_blk_o)));

  a_r10_wr_block_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o && addr_we_o && $past(mode_q) != MODE_S2)
      |-> (addr_o[ADDR_W-1] == $past(wr_blk_o)));
endmodule

bind dbuf_addr_gen dbuf_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_we_i(req_we_i),
  .addr_o(addr_o), .addr_valid_o(addr_valid_o), .addr_we_o(addr_we_o),
  .rd_blk_o(rd_blk_o), .wr_blk_o(wr_blk_o), .mode_q(mode_q)
);

// File: tb/dbuf_addr_gen_tb_top.sv
`timescale 1ns/1ps
module dbuf_addr_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        frame_start_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_we_i = 1'b0;
  logic [6:0]  req_chan_i = '0;
  logic [4:0]  req_strm_i = '0;
  logic [12:0] addr_o;
  logic        addr_valid_o, addr_we_o, rd_blk_o, wr_blk_o;

  always #2 clk_i = ~clk_i;

  dbuf_addr_gen dut_i (.*);

  typedef struct { int addr; bit we; string req; } exp_t;
  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  int   mode_m = 0;
  bit   m_blk[2], pa[2], pb[2];
  bit   done = 0;

  task automatic check(bit good, string req, int act, int exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input int md, input bit we, input int ch, input int st,
                                input bit b, output bit ok, output int a,
                                output bit fa, output bit fb);
    ok = 0; a = 0; fa = 0; fb = 0;
    case (md)
      0: begin
        ok = ch < 32 && st < 24; a = 24*ch + st + (we ? 'h400 : 0) + (b ? 'h800 : 0);
        fa = ch == 31 && st == 23;
      end
      1: begin
        ok = ch < 64 && st < 24; a = 24*ch + st + (we ? 'h800 : 0) + (b ? 'h1000 : 0);
        fa = ch == 63 && st == 23;
      end
      2: begin
        if (we) begin ok = st < 12; a = 12*ch + st + 'h800; fa = ch == 127 && st == 11; end
        else begin ok = st >= 12 && st < 24; a = 12*ch + st - 12; fa = ch == 127 && st == 23; end
        a += b ? 'h1000 : 0;
      end
      default: begin
        if (st < 16) begin ok = ch < 32; a = 16*ch + st + (we ? 'h800 : 0); fb = ch == 31 && st == 15; end
        else begin ok = st < 24; a = 8*ch + st - 16 + (we ? 'hC00 : 'h400); fa = ch == 127 && st == 23; end
        a += b ? 'h1000 : 0;
      end
    endcase
  endfunction

  // driver: push expectation, update model flags, present request for one cycle
  task automatic issue(bit we, int ch, int st, string req);
    bit ok, fa, fb; int a; int d;
    d = we ? 1 : 0;
    model(mode_m, we, ch, st, m_blk[d], ok, a, fa, fb);
    if (ok) begin
      q.push_back('{addr: a, we: we, req: req});
      if (mode_m != 3) begin
        if (fa) m_blk[d] = ~m_blk[d];
      end else if ((fa && pb[d]) || (fb && pa[d])) begin
        m_blk[d] = ~m_blk[d]; pa[d] = 0; pb[d] = 0;
      end else begin
        if (fa) pa[d] = 1;
        if (fb) pb[d] = 1;
      end
    end
    req_valid_i = 1'b1; req_we_i = we; req_chan_i = 7'(ch); req_strm_i = 5'(st);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (!ok) check(addr_valid_o == 1'b0, "R11 dropped request produced address", int'(addr_valid_o), 0);
  endtask

  task automatic chk_flags(string req);
    check(rd_blk_o == m_blk[0], {req, " rd_blk_o"}, int'(rd_blk_o), int'(m_blk[0]));
    check(wr_blk_o == m_blk[1], {req, " wr_blk_o"}, int'(wr_blk_o), int'(m_blk[1]));
  endtask

  task automatic new_frame(int md);
    mode_i = 2'(md); frame_start_i = 1'b1;
    @(negedge clk_i);
    frame_start_i = 1'b0;
    mode_m = md;
    if (md != 3) begin pa = '{0, 0}; pb = '{0, 0}; end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && addr_valid_o) begin
      if (q.size() == 0) check(1'b0, "R7 unexpected address", int'(addr_o), -1);
      else begin
        exp_t e;
        e = q.pop_front();
        check(int'(addr_o) == e.addr && addr_we_o == e.we, e.req, int'(addr_o), e.addr);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    m_blk = '{0, 0}; pa = '{0, 0}; pb = '{0, 0};
    repeat (3) @(negedge clk_i);
    check(addr_valid_o == 1'b0, "R1 valid in reset", int'(addr_valid_o), 0);
    chk_flags("R1 in reset");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(addr_valid_o == 1'b0, "R1 valid after reset", int'(addr_valid_o), 0);
    chk_flags("R1 after reset");

    // mode 00, default after reset (R1 / R2)
    issue(1, 5, 3, "R2 write");
    issue(0, 5, 3, "R2 read");
    issue(0, 31, 23, "R8 final read mode00");
    chk_flags("R8 mode00 read flip");
    issue(0, 0, 0, "R2 read block1");
    issue(1, 30, 23, "R10 write still block0");
    issue(1, 31, 23, "R9 final write mode00");
    chk_flags("R9 mode00 write flip");
    issue(1, 0, 0, "R2 write block1 bit12 low");
    issue(0, 32, 0, "R11");
    issue(1, 0, 24, "R11");
    chk_flags("R11 flags unchanged");

    // R12: mode change without frame start has no effect
    mode_i = 2'b01;
    issue(0, 40, 0, "R12 mode not latched");
    new_frame(1);

    // mode 01 (R3)
    issue(0, 40, 2, "R3 read block1");
    issue(1, 63, 23, "R9 final write mode01");
    issue(0, 63, 23, "R8 final read mode01");
    chk_flags("R3 mode01 flips");
    issue(1, 10, 10, "R3 write block0");

    // mode 10 (R4)
    new_frame(2);
    issue(1, 126, 0, "R4 write");
    issue(0, 0, 12, "R4 read");
    issue(1, 0, 12, "R11");
    issue(0, 3, 5, "R11");
    issue(0, 127, 23, "R8 final read mode10");
    issue(0, 1, 12, "R4 read block1 back to back");
    issue(1, 127, 11, "R9 final write mode10");
    chk_flags("R4 mode10 flips");

    // mode 11 (R5 / R6)
    new_frame(3);
    issue(1, 124, 16, "R6 fast write");
    issue(1, 31, 0, "R5 slow write");
    issue(0, 4, 16, "R6 fast read");
    issue(0, 1, 0, "R5 slow read");
    issue(1, 127, 23, "R9 fast final write");
    chk_flags("R9 mixed one final only");
    issue(1, 31, 15, "R9 slow final write");
    chk_flags("R9 mixed write flip");
    issue(0, 31, 15, "R8 slow final read");
    chk_flags("R8 mixed one final only");
    issue(0, 127, 23, "R8 fast final read");
    chk_flags("R8 mixed read flip");
    issue(0, 127, 23, "R6 fast final read block0");
    issue(0, 127, 23, "R6 fast final again");
    chk_flags("R8 repeated fast final no flip");
    issue(0, 31, 15, "R8 slow completes frame");
    chk_flags("R8 mixed second flip");
    issue(0, 32, 0, "R11");
    issue(1, 5, 20, "R10 write uses write block");

    repeat (3) @(negedge clk_i);
    check(q.size() == 0, "R7 missing addresses", q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule